// File: doc/BRIEF.md
# Torus-Mesh Shift Matrix Multiplier

This block multiplies two square integer matrices on a grid of N×N processing elements. Each element keeps one operand from the left matrix, one from the right matrix and one accumulator. The grid links wrap around at the edges, so it behaves as a torus. Every transfer goes only to a direct neighbour. There are no shared broadcast lines.

A host first writes the operands into the grid one element at a time. The operands must already be preskewed. Element (i,j) is given left value A[i][(i+j) mod N] and right value B[(i+j) mod N][j]. A start pulse then launches N compute cycles. In each cycle every element multiplies the pair it holds, then passes its left operand one column back and its right operand one row up. In the first cycle the element writes the product into the accumulator. In the later cycles it adds the product to the accumulator. At step l, element (i,j) therefore works on inner index k = (i+j+l) mod N, so each accumulator collects its terms in its own rotated order. After the run, each result is read back through a registered port addressed by row and column.

Top module: `torusMatmul`

## Requirements
- R1: After reset, busy, done, rdErr and rdData are all zero.
- R2: When not busy, a cycle with loadEn high writes loadA and loadB into the element at (loadRow, loadCol). A write attempted while busy is ignored and does not change the result of the run in progress.
- R3: When idle, a start pulse makes busy high from the next clock edge. Busy stays high for exactly N cycles. Done is high for exactly one cycle, the first cycle after busy falls. A start while busy has no effect on the run length.
- R4: The first compute cycle overwrites each accumulator with a fresh product. Nothing carries over from an earlier run.
- R5: In each compute cycle, element (i,j) takes its next left operand from (i,(j+1) mod N) and its next right operand from ((i+1) mod N,j). With preskewed loading, element (i,j) ends with C[i][j] = Σk A[i][k]·B[k][j].
- R6: After a run, every operand is back in the element where it was loaded. A second start with no reload gives the same results.
- R7: A read request (rdEn) while idle returns the accumulator at (rdRow, rdCol) on rdData in the next cycle, with rdErr low.
- R8: A read request while busy sets rdErr high in the next cycle and leaves rdData unchanged.
- R9: Operands are 16-bit two's complement. Accumulators are 40-bit two's complement and exact for all operand values, including -32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadEn | input | 1 | Write operands into one element |
| loadRow | input | log2(N) | Row of the element to write |
| loadCol | input | log2(N) | Column of the element to write |
| loadA | input | 16 | Left-matrix operand, signed |
| loadB | input | 16 | Right-matrix operand, signed |
| start | input | 1 | Begin a multiply run |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse when the run ends |
| rdEn | input | 1 | Read request |
| rdRow | input | log2(N) | Row to read |
| rdCol | input | log2(N) | Column to read |
| rdData | output | 40 | Registered accumulator value, signed |
| rdErr | output | 1 | Last read was issued while busy |

## Verification
Busy is due one edge after start. Done is due N edges after busy rises and lasts one cycle. Read data and rdErr are due one edge after rdEn. The bench drives every input at the falling edge and samples one falling edge after each rising edge it counts. It checks busy on each of the N run cycles and checks done on the cycle after the last one. During a run it injects a read, a write and an extra start, then checks rdErr and the stale data one cycle later. The final results are checked against the products computed in the bench.

// File: rtl/mmPkg.sv
package mmPkg;
  // strobes from the sequencer to the element grid
  typedef struct packed {
    logic loadWr;   // write operands of the addressed element
    logic mulFirst; // product replaces accumulator, operands rotate
    logic mulAcc;   // product adds to accumulator, operands rotate
    logic rdTake;   // capture addressed accumulator
    logic rdFlag;   // read refused while busy
  } mmStrobe_t;
endpackage

// File: rtl/mmCtrl.sv
module mmCtrl
  import mmPkg::*;
#(
  parameter int N = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      loadEn,
  input  logic      start,
  input  logic      rdEn,
  output logic      busy,
  output logic      done,
  output mmStrobe_t strobe
);
  localparam int SW = (N > 1) ? $clog2(N) : 1;
  localparam logic [SW-1:0] LAST = SW'(N - 1);

  logic [SW-1:0] stepCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      stepCnt <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          stepCnt <= '0;
        end
      end else begin
        stepCnt <= stepCnt + 1'b1;
        if (stepCnt == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe.loadWr   = loadEn && !busy;
    strobe.mulFirst = busy && (stepCnt == '0);
    strobe.mulAcc   = busy && (stepCnt != '0);
    strobe.rdTake   = rdEn && !busy;
    strobe.rdFlag   = rdEn && busy;
  end

  // R3: an idle start always launches a run
  p_start_launch_r3: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
  // R3: the last step ends busy and raises done
  p_run_length_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && stepCnt == LAST) |=> (!busy && done));
  // R3: done is a single-cycle pulse
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R2: strobes are mutually exclusive in their groups
  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadWr, strobe.mulFirst, strobe.mulAcc}));
endmodule

// File: rtl/mmPe.sv
module mmPe
  import mmPkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 40
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  mmStrobe_t            strobe,
  input  logic                 sel,
  input  logic signed [DW-1:0] loadA,
  input  logic signed [DW-1:0] loadB,
  input  logic signed [DW-1:0] aIn,
  input  logic signed [DW-1:0] bIn,
  output logic signed [DW-1:0] aOut,
  output logic signed [DW-1:0] bOut,
  output logic signed [AW-1:0] cOut
);
  logic signed [2*DW-1:0] prod;
  logic signed [AW-1:0]   prodExt;

  always_comb begin
    prod    = aOut * bOut;
    prodExt = AW'(prod);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aOut <= '0;
      bOut <= '0;
      cOut <= '0;
    end else if (strobe.loadWr && sel) begin
      aOut <= loadA;
      bOut <= loadB;
    end else if (strobe.mulFirst || strobe.mulAcc) begin
      aOut <= aIn;
      bOut <= bIn;
      cOut <= strobe.mulFirst ? prodExt : (cOut + prodExt);
    end
  end
endmodule

// File: rtl/mmGrid.sv
module mmGrid
  import mmPkg::*;
#(
  parameter int N  = 4,
  parameter int DW = 16,
  parameter int AW = 40
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  mmStrobe_t             strobe,
  input  logic [$clog2(N)-1:0]  loadRow,
  input  logic [$clog2(N)-1:0]  loadCol,
  input  logic signed [DW-1:0]  loadA,
  input  logic signed [DW-1:0]  loadB,
  input  logic [$clog2(N)-1:0]  rdRow,
  input  logic [$clog2(N)-1:0]  rdCol,
  output logic signed [AW-1:0]  rdData,
  output logic                  rdErr
);
  localparam int IW = $clog2(N);

  logic signed [DW-1:0] aNet [N][N];
  logic signed [DW-1:0] bNet [N][N];
  logic signed [AW-1:0] cNet [N][N];

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      localparam int JR = (j + 1) % N;
      localparam int IB = (i + 1) % N;
      logic selHere;
      assign selHere = (loadRow == IW'(i)) && (loadCol == IW'(j));
      mmPe #(.DW(DW), .AW(AW)) u_pe (
        .clk   (clk),
        .rstN  (rstN),
        .strobe(strobe),
        .sel   (selHere),
        .loadA (loadA),
        .loadB (loadB),
        .aIn   (aNet[i][JR]),
        .bIn   (bNet[IB][j]),
        .aOut  (aNet[i][j]),
        .bOut  (bNet[i][j]),
        .cOut  (cNet[i][j])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
      rdErr  <= 1'b0;
    end else if (strobe.rdTake) begin
      rdData <= cNet[rdRow][rdCol];
      rdErr  <= 1'b0;
    end else if (strobe.rdFlag) begin
      rdErr <= 1'b1;
    end
  end

  // R8: a refused read leaves the data register untouched
  p_stale_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdFlag |=> (rdErr && $stable(rdData)));
  // R7: an accepted read clears the error flag
  p_read_ok_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdTake |=> !rdErr);
endmodule

// File: rtl/torusMatmul.sv
module torusMatmul
  import mmPkg::*;
#(
  parameter int N  = 4,
  parameter int DW = 16,
  parameter int AW = 40
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 loadEn,
  input  logic [$clog2(N)-1:0] loadRow,
  input  logic [$clog2(N)-1:0] loadCol,
  input  logic [DW-1:0]        loadA,
  input  logic [DW-1:0]        loadB,
  input  logic                 start,
  output logic                 busy,
  output logic                 done,
  input  logic                 rdEn,
  input  logic [$clog2(N)-1:0] rdRow,
  input  logic [$clog2(N)-1:0] rdCol,
  output logic [AW-1:0]        rdData,
  output logic                 rdErr
);
  mmStrobe_t strobe;

  mmCtrl #(.N(N)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .loadEn(loadEn),
    .start (start),
    .rdEn  (rdEn),
    .busy  (busy),
    .done  (done),
    .strobe(strobe)
  );

  mmGrid #(.N(N), .DW(DW), .AW(AW)) u_grid (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .loadRow(loadRow),
    .loadCol(loadCol),
    .loadA  (loadA),
    .loadB  (loadB),
    .rdRow  (rdRow),
    .rdCol  (rdCol),
    .rdData (rdData),
    .rdErr  (rdErr)
  );
endmodule

// File: tb/torusMatmul_bench.sv
`timescale 1ns/1ps
module torusMatmul_bench;
  localparam int N  = 4;
  localparam int DW = 16;
  localparam int AW = 40;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadEn = 1'b0, start = 1'b0, rdEn = 1'b0;
  logic [IW-1:0] loadRow = '0, loadCol = '0, rdRow = '0, rdCol = '0;
  logic [DW-1:0] loadA = '0, loadB = '0;
  logic busy, done, rdErr;
  logic [AW-1:0] rdData;

  int checks = 0;
  int failures = 0;
  int matA [N][N];
  int matB [N][N];
  bit finished = 1'b0;

  always #4 clk = ~clk;

  torusMatmul #(.N(N), .DW(DW), .AW(AW)) u_torusMatmul (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadRow(loadRow), .loadCol(loadCol),
    .loadA(loadA), .loadB(loadB), .start(start), .busy(busy), .done(done),
    .rdEn(rdEn), .rdRow(rdRow), .rdCol(rdCol), .rdData(rdData), .rdErr(rdErr)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint expC(input int i, input int j);
    longint s = 0;
    for (int k = 0; k < N; k++) s += longint'(matA[i][k]) * longint'(matB[k][j]);
    return s;
  endfunction

  task automatic loadAll();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        @(negedge clk);
        loadEn = 1'b1; loadRow = IW'(i); loadCol = IW'(j);
        loadA = DW'(matA[i][(i + j) % N]);
        loadB = DW'(matB[(i + j) % N][j]);
      end
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  // run one multiply; disturb injects read, write and start while busy
  task automatic runMul(input bit disturb);
    logic [AW-1:0] prev;
    prev = rdData;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R3 busy after start", busy, 1);
    check("R3 done low at start", done, 0);
    for (int c = 1; c < N; c++) begin
      if (disturb && c == 1) begin
        rdEn = 1'b1; rdRow = '0; rdCol = '0;
        loadEn = 1'b1; loadRow = '0; loadCol = '0;
        loadA = 16'h1234; loadB = 16'h4321;
        start = 1'b1;
      end
      @(negedge clk);
      if (disturb && c == 1) begin
        rdEn = 1'b0; loadEn = 1'b0; start = 1'b0;
        check("R8 rdErr on busy read", rdErr, 1);
        check("R8 stale rdData", longint'($signed(rdData)), longint'($signed(prev)));
      end
      check("R3 busy held", busy, 1);
    end
    @(negedge clk);
    check("R3 busy falls after N", busy, 0);
    check("R3 done pulse", done, 1);
    @(negedge clk);
    check("R3 done one cycle", done, 0);
  endtask

  task automatic readAll(input string tag);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        @(negedge clk);
        rdEn = 1'b1; rdRow = IW'(i); rdCol = IW'(j);
        @(negedge clk);
        rdEn = 1'b0;
        check({tag, " R7 rdErr low"}, rdErr, 0);
        check(tag, longint'($signed(rdData)), expC(i, j));
      end
  endtask

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    check("R1 busy reset", busy, 0);
    check("R1 done reset", done, 0);
    check("R1 rdErr reset", rdErr, 0);
    check("R1 rdData reset", longint'(rdData), 0);
    rstN = 1'b1;

    // identity times a ramp (R5)
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        matA[i][j] = (i == j) ? 1 : 0;
        matB[i][j] = i * N + j - 7;
      end
    loadAll(); runMul(1'b0); readAll("R5 identity");

    // extremes (R9), with disturbances while busy (R2 R8)
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        matA[i][j] = -32768; matB[i][j] = -32768;
      end
    loadAll(); runMul(1'b1); readAll("R9 R2 extremes");
    // rerun without reload: operands restored and accumulators restart (R6 R4)
    runMul(1'b0); readAll("R6 R4 rerun");

    // mixed signs at the range ends (R9)
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        matA[i][j] = ((i + j) % 2 == 0) ? 32767 : -32768;
        matB[i][j] = ((i * j) % 2 == 0) ? -32768 : 32767;
      end
    loadAll(); runMul(1'b0); readAll("R9 mixed");

    // random matrices (R5)
    for (int t = 0; t < 6; t++) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++) begin
          matA[i][j] = int'($signed(16'($urandom())));
          matB[i][j] = int'($signed(16'($urandom())));
        end
      loadAll(); runMul(t == 2); readAll("R5 random");
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule